// File: doc/BRIEF.md
# Packet Counter and Chain Status Controller

This block keeps the count of descriptor packets that software has handed to a chained packet engine. Software adds to the count through a write port. Each completion strobe from the datapath removes one from the count. A completion also compares the finished packet's chain flag with the count that is left, and a mismatch raises one of two sticky flags. The first is a chain error, raised when the chain ends while packets are still queued. The second is a stall, raised when the chain continues but nothing is queued. During a stall the block holds a wait-for-buffer output high.

Other sticky flags record:
- the error pulses from the datapath,
- a packet that asked for notification,
- the count reaching zero.

A summary interrupt flag collects these events. Software gates that flag with an enable input to drive the interrupt line. Every flag clears when software writes 1 to it. The tag of the last completed packet sits in the top byte of the status word.

A three-state machine tracks the queue. The states are EMPTY (count zero, no stall), ACTIVE (count non-zero) and STALL (count zero after a completion that asked to continue).
- EMPTY goes to ACTIVE when the next count is non-zero.
- EMPTY goes to STALL when a chained completion leaves the count at zero.
- ACTIVE goes to EMPTY when the last packet completes with its chain flag clear.
- ACTIVE goes to STALL when the last packet completes with its chain flag set.
- STALL goes to ACTIVE when an increment makes the count non-zero.
- STALL goes to EMPTY when a completion with its chain flag clear arrives while the count stays zero.
- In every other case the state holds.

Top module: `pkt_chain_stat`

## Requirements
- R1: During and directly after reset, the count is 0, the status word is 0, and both `wait_buf` and `irq` are 0.
- R2: A write with `sw_inc_we` high adds `sw_inc_val` to the count. The sum saturates at 255.
- R3: A completion (`done_vld`) lowers the count by one, and never below zero. If an increment arrives in the same cycle, the next count is the saturated sum of that reduced count and the increment.
- R4: In this list, "remaining" means the count after the completion's decrement and before any same-cycle increment. Status bit 3 (chain error) is set by a completion that has `done_chain`=0 while the remaining count is non-zero.
- R5: Status bit 4 (stall) is set by a completion that has `done_chain`=1 while the remaining count is zero. `wait_buf` is high while the state machine is in STALL.
- R6: Status bit 5 (count zero) is set when the count goes from a non-zero value to zero.
- R7: Status bit 6 (packet done) is set by a completion only when `done_irq_req` is 1.
- R8: Status bit 7 (interrupt request) is set in the same cycle as any set of bits 0 to 3, 5 or 6. The `irq` output equals bit 7 AND `cfg_irq_en`.
- R9: Status bits 7:0 are cleared by writes with `sw_clr_we`, where each 1 in `sw_clr_mask` clears the matching bit. A set and a clear of the same bit in the same cycle leave the bit set.
- R10: Status bits 2:0 capture the `done_err` pulses. Bits 31:24 hold the tag of the most recent completion. Bits 23:8 read as zero.
- R11: A stall event sets bit 7 only when `cfg_test_irq` is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| cfg_irq_en | input | 1 | Interrupt output enable |
| cfg_test_irq | input | 1 | Lets a stall event raise the interrupt flag |
| sw_inc_we | input | 1 | Count increment write strobe |
| sw_inc_val | input | 8 | Value added to the count |
| sw_clr_we | input | 1 | Status clear write strobe |
| sw_clr_mask | input | 8 | Write-1-to-clear mask for status bits 7:0 |
| done_vld | input | 1 | Packet completion strobe |
| done_chain | input | 1 | Chain flag of the finished packet |
| done_irq_req | input | 1 | Notification request of the finished packet |
| done_tag | input | 8 | Tag of the finished packet |
| done_err | input | 3 | Datapath error pulses |
| pkt_count | output | 8 | Current packet count |
| status | output | 32 | Tag and sticky flags |
| wait_buf | output | 1 | Engine is waiting for a new buffer |
| irq | output | 1 | Gated interrupt line |

## Verification
A wrong count or a wrong state in the machine shows up on `pkt_count` or `wait_buf` one clock after the edge that caused it. It also shows up later as a missing or extra chain-error, stall or count-zero flag when the next completion arrives. A sticky flag that clears when it should not, or that stays set when it should clear, is visible in `status` on the cycle after the write. The same is true of the interrupt summary bit, which also reaches `irq` in that cycle whenever the enable is high. The table therefore checks every output after every cycle. This catches a divergence within one cycle and does not wait for a final readout.

// File: rtl/pcs_pkg.sv
package pcs_pkg;
    typedef enum logic [1:0] {
        ST_EMPTY  = 2'd0,
        ST_ACTIVE = 2'd1,
        ST_STALL  = 2'd2
    } pcs_state_e;
endpackage

// File: rtl/pcs_counter.sv
module pcs_counter #(
    parameter int CNT_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             inc_en,
    input  logic [CNT_W-1:0] inc_val,
    input  logic             dec,
    output logic [CNT_W-1:0] count,
    output logic             rem_zero,
    output logic             nxt_zero,
    output logic             hit_zero
);
    localparam logic [CNT_W-1:0] CNT_MAX = {CNT_W{1'b1}};

    logic [CNT_W-1:0] rem;
    logic [CNT_W:0]   sum;
    logic [CNT_W-1:0] nxt;

    always_comb begin
        rem = (dec && count != '0) ? count - 1'b1 : count;
        sum = {1'b0, rem} + {1'b0, (inc_en ? inc_val : '0)};
        nxt = sum[CNT_W] ? CNT_MAX : sum[CNT_W-1:0];
    end

    assign rem_zero = (rem == '0);
    assign nxt_zero = (nxt == '0);
    assign hit_zero = (count != '0) && (nxt == '0);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) count <= '0;
        else        count <= nxt;
    end
endmodule

// File: rtl/pcs_flags.sv
module pcs_flags #(
    parameter int N = 8
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [N-1:0] set,
    input  logic [N-1:0] clr,
    output logic [N-1:0] flags
);
    for (genvar i = 0; i < N; i++) begin : g_bit
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)      flags[i] <= 1'b0;
            else if (set[i]) flags[i] <= 1'b1;
            else if (clr[i]) flags[i] <= 1'b0;
        end
    end
endmodule

// File: rtl/pcs_fsm.sv
module pcs_fsm
    import pcs_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic cmp,
    input  logic chain,
    input  logic nxt_zero,
    output logic wait_buf
);
    pcs_state_e state, state_nx;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state <= ST_EMPTY;
        else        state <= state_nx;
    end

    always_comb begin
        state_nx = state;
        unique case (state)
            ST_EMPTY: begin
                if (!nxt_zero)          state_nx = ST_ACTIVE;
                else if (cmp && chain)  state_nx = ST_STALL;
            end
            ST_ACTIVE: begin
                if (nxt_zero)           state_nx = (cmp && chain) ? ST_STALL : ST_EMPTY;
            end
            ST_STALL: begin
                if (!nxt_zero)          state_nx = ST_ACTIVE;
                else if (cmp && !chain) state_nx = ST_EMPTY;
            end
            default:                    state_nx = ST_EMPTY;
        endcase
    end

    always_comb begin
        wait_buf = (state == ST_STALL);
    end
endmodule

// File: rtl/pkt_chain_stat.sv
module pkt_chain_stat #(
    parameter int CNT_W = 8,
    parameter int TAG_W = 8,
    parameter int NERR  = 3
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cfg_irq_en,
    input  logic              cfg_test_irq,
    input  logic              sw_inc_we,
    input  logic [CNT_W-1:0]  sw_inc_val,
    input  logic              sw_clr_we,
    input  logic [NERR+4:0]   sw_clr_mask,
    input  logic              done_vld,
    input  logic              done_chain,
    input  logic              done_irq_req,
    input  logic [TAG_W-1:0]  done_tag,
    input  logic [NERR-1:0]   done_err,
    output logic [CNT_W-1:0]  pkt_count,
    output logic [31:0]       status,
    output logic              wait_buf,
    output logic              irq
);
    localparam int NFLAG  = NERR + 5;
    localparam int B_CHN  = NERR;
    localparam int B_STL  = NERR + 1;
    localparam int B_ZERO = NERR + 2;
    localparam int B_DONE = NERR + 3;
    localparam int B_IRQ  = NERR + 4;
    localparam int PAD    = 32 - TAG_W - NFLAG;

    logic             rem_zero, nxt_zero, hit_zero;
    logic [NFLAG-1:0] set_v, clr_v, flags;
    logic [TAG_W-1:0] tag_q;

    pcs_counter #(.CNT_W(CNT_W)) u_cnt (
        .clk      (clk),
        .rst_n    (rst_n),
        .inc_en   (sw_inc_we),
        .inc_val  (sw_inc_val),
        .dec      (done_vld),
        .count    (pkt_count),
        .rem_zero (rem_zero),
        .nxt_zero (nxt_zero),
        .hit_zero (hit_zero)
    );

    pcs_fsm u_fsm (
        .clk      (clk),
        .rst_n    (rst_n),
        .cmp      (done_vld),
        .chain    (done_chain),
        .nxt_zero (nxt_zero),
        .wait_buf (wait_buf)
    );

    always_comb begin
        set_v              = '0;
        set_v[NERR-1:0]    = done_err;
        set_v[B_CHN]       = done_vld && !done_chain && !rem_zero;
        set_v[B_STL]       = done_vld && done_chain && rem_zero;
        set_v[B_ZERO]      = hit_zero;
        set_v[B_DONE]      = done_vld && done_irq_req;
        set_v[B_IRQ]       = (|set_v[B_CHN:0]) | set_v[B_ZERO] | set_v[B_DONE]
                           | (set_v[B_STL] & cfg_test_irq);
        clr_v              = sw_clr_we ? sw_clr_mask : '0;
    end

    pcs_flags #(.N(NFLAG)) u_flg (
        .clk   (clk),
        .rst_n (rst_n),
        .set   (set_v),
        .clr   (clr_v),
        .flags (flags)
    );

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)        tag_q <= '0;
        else if (done_vld) tag_q <= done_tag;
    end

    assign status = {tag_q, {PAD{1'b0}}, flags};
    assign irq    = flags[B_IRQ] & cfg_irq_en;
endmodule

// File: rtl/pcs_check.sv
module pcs_check #(
    parameter int CNT_W = 8,
    parameter int TAG_W = 8,
    parameter int NERR  = 3
) (
    input logic             clk,
    input logic             rst_n,
    input logic             cfg_irq_en,
    input logic             sw_inc_we,
    input logic             sw_clr_we,
    input logic             done_vld,
    input logic             done_chain,
    input logic             done_irq_req,
    input logic [TAG_W-1:0] done_tag,
    input logic [CNT_W-1:0] pkt_count,
    input logic [31:0]      status,
    input logic             wait_buf,
    input logic             irq
);
    localparam int NFLAG = NERR + 5;

    a_r2_no_drop: assert property (@(posedge clk) disable iff (!rst_n)
        !done_vld |=> pkt_count >= $past(pkt_count));

    a_r3_step: assert property (@(posedge clk) disable iff (!rst_n)
        (done_vld && !sw_inc_we) |=>
        pkt_count == (($past(pkt_count) == '0) ? '0 : CNT_W'($past(pkt_count) - 1'b1)));

    a_r4_chain_err: assert property (@(posedge clk) disable iff (!rst_n)
        (done_vld && !done_chain && pkt_count > CNT_W'(1)) |=> status[NERR]);

    a_r5_wait_empty: assert property (@(posedge clk) disable iff (!rst_n)
        wait_buf |-> pkt_count == '0);

    a_r7_done: assert property (@(posedge clk) disable iff (!rst_n)
        (done_vld && done_irq_req) |=> status[NERR+3]);

    a_r8_irq_gate: assert property (@(posedge clk) disable iff (!rst_n)
        !cfg_irq_en |-> !irq);

    a_r9_sticky: assert property (@(posedge clk) disable iff (!rst_n)
        !sw_clr_we |=>
        ((status[NFLAG-1:0] & $past(status[NFLAG-1:0])) == $past(status[NFLAG-1:0])));

    a_r10_tag: assert property (@(posedge clk) disable iff (!rst_n)
        done_vld |=> status[31 -: TAG_W] == $past(done_tag));
endmodule

bind pkt_chain_stat pcs_check #(.CNT_W(CNT_W), .TAG_W(TAG_W), .NERR(NERR)) u_chk (
    .clk          (clk),
    .rst_n        (rst_n),
    .cfg_irq_en   (cfg_irq_en),
    .sw_inc_we    (sw_inc_we),
    .sw_clr_we    (sw_clr_we),
    .done_vld     (done_vld),
    .done_chain   (done_chain),
    .done_irq_req (done_irq_req),
    .done_tag     (done_tag),
    .pkt_count    (pkt_count),
    .status       (status),
    .wait_buf     (wait_buf),
    .irq          (irq)
);

// File: tb/sim_pkt_chain_stat.sv
`timescale 1ns/1ps
module sim_pkt_chain_stat;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        cfg_irq_en = 1'b0, cfg_test_irq = 1'b0;
    logic        sw_inc_we = 1'b0, sw_clr_we = 1'b0;
    logic [7:0]  sw_inc_val = '0, sw_clr_mask = '0;
    logic        done_vld = 1'b0, done_chain = 1'b0, done_irq_req = 1'b0;
    logic [7:0]  done_tag = '0;
    logic [2:0]  done_err = '0;
    logic [7:0]  pkt_count;
    logic [31:0] status;
    logic        wait_buf, irq;

    int n_chk = 0;
    int n_bad = 0;

    always #10 clk = ~clk;

    pkt_chain_stat u0 (
        .clk(clk), .rst_n(rst_n), .cfg_irq_en(cfg_irq_en), .cfg_test_irq(cfg_test_irq),
        .sw_inc_we(sw_inc_we), .sw_inc_val(sw_inc_val), .sw_clr_we(sw_clr_we),
        .sw_clr_mask(sw_clr_mask), .done_vld(done_vld), .done_chain(done_chain),
        .done_irq_req(done_irq_req), .done_tag(done_tag), .done_err(done_err),
        .pkt_count(pkt_count), .status(status), .wait_buf(wait_buf), .irq(irq)
    );

    typedef struct packed {
        logic [3:0] req;
        logic [7:0] inc;
        logic       cmp, chain, rq;
        logic [7:0] tag;
        logic [2:0] err;
        logic [7:0] clr;
        logic       ien, tst;
        logic [7:0] e_cnt, e_flg, e_tag;
        logic       e_wt, e_irq;
    } vec_t;

    // flag bits: 2:0 errors, 3 chain error, 4 stall, 5 count zero, 6 done, 7 irq
    localparam vec_t VECS [16] = '{
        '{4'd2,  8'd3,   1'b0,1'b0,1'b0, 8'h00, 3'b000, 8'h00, 1'b0,1'b0, 8'd3,   8'h00, 8'h00, 1'b0,1'b0}, // R2 add
        '{4'd3,  8'd0,   1'b1,1'b1,1'b0, 8'h11, 3'b000, 8'h00, 1'b0,1'b0, 8'd2,   8'h00, 8'h11, 1'b0,1'b0}, // R3 step, R10 tag
        '{4'd7,  8'd0,   1'b1,1'b1,1'b1, 8'h22, 3'b000, 8'h00, 1'b1,1'b0, 8'd1,   8'hC0, 8'h22, 1'b0,1'b1}, // R7 done, R8 irq
        '{4'd9,  8'd0,   1'b0,1'b0,1'b0, 8'h00, 3'b000, 8'hC0, 1'b1,1'b0, 8'd1,   8'h00, 8'h22, 1'b0,1'b0}, // R9 clear
        '{4'd6,  8'd0,   1'b1,1'b0,1'b0, 8'h33, 3'b000, 8'h00, 1'b1,1'b0, 8'd0,   8'hA0, 8'h33, 1'b0,1'b1}, // R6 reach zero
        '{4'd9,  8'd0,   1'b0,1'b0,1'b0, 8'h00, 3'b000, 8'hFF, 1'b0,1'b0, 8'd0,   8'h00, 8'h33, 1'b0,1'b0}, // R9 clear all
        '{4'd5,  8'd0,   1'b1,1'b1,1'b0, 8'h44, 3'b000, 8'h00, 1'b0,1'b0, 8'd0,   8'h10, 8'h44, 1'b1,1'b0}, // R5 stall, R11 no irq
        '{4'd5,  8'd2,   1'b0,1'b0,1'b0, 8'h00, 3'b000, 8'h00, 1'b0,1'b0, 8'd2,   8'h10, 8'h44, 1'b0,1'b0}, // R5 resume
        '{4'd4,  8'd0,   1'b1,1'b0,1'b0, 8'h55, 3'b000, 8'h10, 1'b0,1'b0, 8'd1,   8'h88, 8'h55, 1'b0,1'b0}, // R4 chain error, R8 gated
        '{4'd9,  8'd0,   1'b0,1'b0,1'b0, 8'h00, 3'b000, 8'h88, 1'b1,1'b0, 8'd1,   8'h00, 8'h55, 1'b0,1'b0}, // R9
        '{4'd3,  8'd5,   1'b1,1'b1,1'b0, 8'h66, 3'b000, 8'h00, 1'b1,1'b0, 8'd5,   8'h10, 8'h66, 1'b0,1'b0}, // R3 same cycle, R5
        '{4'd10, 8'd0,   1'b0,1'b0,1'b0, 8'h00, 3'b101, 8'h10, 1'b1,1'b0, 8'd5,   8'h85, 8'h66, 1'b0,1'b1}, // R10 errors
        '{4'd9,  8'd0,   1'b0,1'b0,1'b0, 8'h00, 3'b010, 8'h80, 1'b1,1'b0, 8'd5,   8'h87, 8'h66, 1'b0,1'b1}, // R9 set wins
        '{4'd9,  8'd0,   1'b0,1'b0,1'b0, 8'h00, 3'b000, 8'hFF, 1'b1,1'b0, 8'd5,   8'h00, 8'h66, 1'b0,1'b0}, // R9
        '{4'd2,  8'd255, 1'b0,1'b0,1'b0, 8'h00, 3'b000, 8'h00, 1'b1,1'b0, 8'd255, 8'h00, 8'h66, 1'b0,1'b0}, // R2 saturate
        '{4'd3,  8'd1,   1'b1,1'b1,1'b0, 8'h77, 3'b000, 8'h00, 1'b1,1'b0, 8'd255, 8'h00, 8'h77, 1'b0,1'b0}  // R3 net change
    };

    task automatic finish_run();
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    endtask

    task automatic check(input string tag, input logic [7:0] e_cnt, input logic [31:0] e_stat,
                         input logic e_wt, input logic e_irq);
        n_chk++;
        if (pkt_count !== e_cnt || status !== e_stat || wait_buf !== e_wt || irq !== e_irq) begin
            n_bad++;
            $display("FAIL %s: cnt=%0d stat=%h wait=%b irq=%b expected cnt=%0d stat=%h wait=%b irq=%b",
                     tag, pkt_count, status, wait_buf, irq, e_cnt, e_stat, e_wt, e_irq);
        end
    endtask

    task automatic drive(input vec_t v);
        sw_inc_we    = (v.inc != 8'd0);
        sw_inc_val   = v.inc;
        done_vld     = v.cmp;
        done_chain   = v.chain;
        done_irq_req = v.rq;
        done_tag     = v.tag;
        done_err     = v.err;
        sw_clr_we    = (v.clr != 8'd0);
        sw_clr_mask  = v.clr;
        cfg_irq_en   = v.ien;
        cfg_test_irq = v.tst;
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        n_bad++;
        $display("FAIL watchdog: run did not end, expected completion");
        finish_run();
    end

    initial begin
        vec_t idle;
        vec_t d;
        idle = '0;
        #5;
        check("R1 reset", 8'd0, 32'h0, 1'b0, 1'b0);
        @(negedge clk);
        rst_n = 1'b1;
        for (int i = 0; i < 16; i++) begin
            drive(VECS[i]);
            @(negedge clk);
            check($sformatf("R%0d row %0d", VECS[i].req, i), VECS[i].e_cnt,
                  {VECS[i].e_tag, 16'h0, VECS[i].e_flg}, VECS[i].e_wt, VECS[i].e_irq);
        end
        // R1: reset in the middle of a run
        drive(idle);
        rst_n = 1'b0;
        #5;
        check("R1 mid-run reset", 8'd0, 32'h0, 1'b0, 1'b0);
        @(negedge clk);
        rst_n = 1'b1;
        // R11: test control lets the stall event raise the interrupt
        d = '0; d.cmp = 1'b1; d.chain = 1'b1; d.tag = 8'h88; d.ien = 1'b1; d.tst = 1'b1;
        drive(d);
        @(negedge clk);
        check("R11 forced irq", 8'd0, {8'h88, 16'h0, 8'h90}, 1'b1, 1'b1);
        // R3 floor, R4 no chain error at zero, R5 leave stall on unchained completion
        d = '0; d.cmp = 1'b1; d.tag = 8'h99; d.clr = 8'h90; d.ien = 1'b1;
        drive(d);
        @(negedge clk);
        check("R4 chain end at zero", 8'd0, {8'h99, 16'h0, 8'h00}, 1'b0, 1'b0);
        drive(idle);
        @(negedge clk);
        finish_run();
    end
endmodule